// File: doc/BRIEF.md
# 16QAM Quadrature Modulator Datapath

This block turns a serial bit stream into a digital 16QAM passband sample stream. Each group of four input bits forms one symbol. The first two bits of the group go to the in-phase rail and the last two go to the quadrature rail. Each rail converts its bit pair into one of four signed amplitude levels. An internal phase-accumulator oscillator produces a cosine and a sine carrier. The in-phase level multiplies the cosine, the quadrature level multiplies the sine, and the saturated sum of the two products is the output sample.

The host holds `start` high and presents one new bit on every clock. The four-bit group appears on `sym_out` so that it can be observed. Dropping `start` clears the whole datapath, and the next rise of `start` begins a new symbol and a new carrier cycle at phase zero. The output samples are meant for a DAC or for a later filter stage.

Top module: `qam16_modulator`

## Requirements
- R1: While `rst` is high, or after any clock edge at which `start` was low, `sym_out`, `lvl_i`, `lvl_q` and `sample_out` are all zero, and the bit count and the oscillator phase restart from zero.
- R2: With `start` high, one bit is captured per clock. On the edge that captures the fourth bit of a group, `sym_out` becomes that group, with the first bit in bit 3 and the last bit in bit 0. It holds that value until the next group completes.
- R3: The rails map their bit pairs in Gray order: 00 → −3·AMP, 01 → −AMP, 11 → +AMP, 10 → +3·AMP, with AMP = 2048 by default. `lvl_i` takes its pair from `sym_out[3:2]` and `lvl_q` takes its pair from `sym_out[1:0]`.
- R4: The levels change one clock after `sym_out` takes a new symbol, and they hold through the remaining three clocks of that symbol.
- R5: The phase advances by PHASE_INC = 256 per clock in a 12-bit accumulator. Its top four bits k select sin = round(511·sin(2πk/16)), and the cosine uses k+4. Each carrier is a 10-bit signed value padded with six zero bits below it, giving 16 bits.
- R6: `sample_out` after clock n equals ((lvl_i·cos16 + lvl_q·sin16) >>> 13), computed with full precision. The levels and carriers in this formula are the registered values after clock n−2, and the shift rounds toward minus infinity.
- R7: The shifted sum is clamped to the range [−32768, 32767], so it never wraps. With both levels at ±3·AMP, the ±45° carrier phases reach both limits.
- R8: The sixteen symbol values produce sixteen distinct (`lvl_i`, `lvl_q`) pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run enable; while low it clears the datapath |
| bit_in | input | 1 | Serial data bit, one per clock while running |
| sym_out | output | 4 | Most recently completed four-bit group |
| lvl_i | output | LVL_W | Signed in-phase amplitude level |
| lvl_q | output | LVL_W | Signed quadrature amplitude level |
| sample_out | output | OUT_W | Signed modulated passband sample |

## Verification
The assertions assume that `start` stays high for whole symbols. Under that assumption the bit count marks symbol boundaries, and the levels move only on the clock after a completed group. The stimulus raises `start` at a negative edge and lowers it only after a full group, so no group is left partly captured. The properties do not depend on the data, so the bench drives every symbol code, runs of same-sign corner symbols to force saturation, and a restart after `start` has been low.

// File: rtl/qam16_pkg.sv
package qam16_pkg;

  // Symbol and rail geometry for 16 constellation points
  localparam int SYM_BITS  = 4;
  localparam int RAIL_BITS = 2;
  localparam int RAILS     = SYM_BITS / RAIL_BITS;

  // Carrier table resolution: 16 phase steps per turn
  localparam int LUT_IDX_W = 4;

  // Gray-coded level weight for one rail
  function automatic int gray_weight(input logic [RAIL_BITS-1:0] pair);
    case (pair)
      2'b00:   return -3;
      2'b01:   return -1;
      2'b11:   return 1;
      default: return 3;
    endcase
  endfunction

  // sin of (k * 22.5 degrees) in thousandths, k = 0..4
  function automatic int quarter_milli(input int k);
    case (k)
      0:       return 0;
      1:       return 383;
      2:       return 707;
      3:       return 924;
      default: return 1000;
    endcase
  endfunction

endpackage

// File: rtl/qam16_serial_split.sv
module qam16_serial_split
  import qam16_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                bit_in,
  output logic [SYM_BITS-1:0] sym_o,
  output logic                sym_stb_o,
  output logic [$clog2(SYM_BITS)-1:0] bit_cnt_o
);

  localparam int CNT_W = $clog2(SYM_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_BITS - 1);

  logic [CNT_W-1:0]    cnt_q;
  logic [SYM_BITS-2:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst || !start) begin
      cnt_q     <= '0;
      shift_q   <= '0;
      sym_o     <= '0;
      sym_stb_o <= 1'b0;
    end else begin
      cnt_q     <= cnt_q + 1'b1;
      shift_q   <= {shift_q[SYM_BITS-3:0], bit_in};
      sym_stb_o <= (cnt_q == LAST);
      if (cnt_q == LAST) begin
        sym_o <= {shift_q, bit_in};
      end
    end
  end

  assign bit_cnt_o = cnt_q;

endmodule

// File: rtl/qam16_level_map.sv
module qam16_level_map
  import qam16_pkg::*;
#(
  parameter int LVL_W = 16,
  parameter int AMP   = 2048
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    sym_stb,
  input  logic [SYM_BITS-1:0]     sym_i,
  output logic signed [LVL_W-1:0] lvl_i_o,
  output logic signed [LVL_W-1:0] lvl_q_o
);

  logic [RAILS*LVL_W-1:0] lvl_bus;

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    logic [RAIL_BITS-1:0]    pair;
    logic signed [LVL_W-1:0] level_q;

    assign pair = sym_i[SYM_BITS-1-RAIL_BITS*r -: RAIL_BITS];

    always_ff @(posedge clk) begin
      if (rst || !start) begin
        level_q <= '0;
      end else if (sym_stb) begin
        level_q <= LVL_W'(gray_weight(pair) * AMP);
      end
    end

    assign lvl_bus[r*LVL_W +: LVL_W] = level_q;
  end

  assign lvl_i_o = lvl_bus[0 +: LVL_W];
  assign lvl_q_o = lvl_bus[LVL_W +: LVL_W];

endmodule

// File: rtl/qam16_nco.sv
module qam16_nco
  import qam16_pkg::*;
#(
  parameter int PHASE_W   = 12,
  parameter int PHASE_INC = 256,
  parameter int NCO_W     = 10,
  parameter int CAR_PAD   = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  output logic signed [NCO_W+CAR_PAD-1:0] cos_o,
  output logic signed [NCO_W+CAR_PAD-1:0] sin_o
);

  localparam int CAR_W = NCO_W + CAR_PAD;
  localparam int PEAK  = (1 << (NCO_W - 1)) - 1;

  logic [PHASE_W-1:0]   phase_q;
  logic [LUT_IDX_W-1:0] idx;
  logic [2*CAR_W-1:0]   car_bus;

  assign idx = phase_q[PHASE_W-1 -: LUT_IDX_W];

  function automatic logic signed [NCO_W-1:0] sine_code(input logic [LUT_IDX_W-1:0] k);
    int sel;
    int mag;
    sel = k[2] ? (4 - int'(k[1:0])) : int'(k[1:0]);
    mag = (PEAK * quarter_milli(sel) + 500) / 1000;
    return NCO_W'(k[3] ? -mag : mag);
  endfunction

  always_ff @(posedge clk) begin
    if (rst || !start) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PHASE_W'(PHASE_INC);
    end
  end

  // g = 0: cosine (quarter-turn ahead), g = 1: sine
  for (genvar g = 0; g < 2; g++) begin : g_car
    localparam logic [LUT_IDX_W-1:0] OFS = (g == 0) ? LUT_IDX_W'(4) : LUT_IDX_W'(0);
    logic [CAR_W-1:0] car_q;

    always_ff @(posedge clk) begin
      if (rst || !start) begin
        car_q <= '0;
      end else begin
        car_q <= {sine_code(idx + OFS), {CAR_PAD{1'b0}}};
      end
    end

    assign car_bus[g*CAR_W +: CAR_W] = car_q;
  end

  assign cos_o = car_bus[0 +: CAR_W];
  assign sin_o = car_bus[CAR_W +: CAR_W];

endmodule

// File: rtl/qam16_mixer.sv
module qam16_mixer #(
  parameter int LVL_W = 16,
  parameter int CAR_W = 16,
  parameter int OUT_W = 16,
  parameter int SHIFT = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic signed [LVL_W-1:0] lvl_i,
  input  logic signed [LVL_W-1:0] lvl_q,
  input  logic signed [CAR_W-1:0] car_cos,
  input  logic signed [CAR_W-1:0] car_sin,
  output logic signed [OUT_W-1:0] sample_o
);

  localparam int PROD_W = LVL_W + CAR_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI =
    {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] SAT_LO =
    {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod_i_q;
  logic signed [PROD_W-1:0] prod_q_q;
  logic signed [SUM_W-1:0]  sum_c;
  logic signed [SUM_W-1:0]  shift_c;

  always_ff @(posedge clk) begin
    if (rst || !start) begin
      prod_i_q <= '0;
      prod_q_q <= '0;
    end else begin
      prod_i_q <= PROD_W'(lvl_i) * PROD_W'(car_cos);
      prod_q_q <= PROD_W'(lvl_q) * PROD_W'(car_sin);
    end
  end

  always_comb begin
    sum_c   = SUM_W'(prod_i_q) + SUM_W'(prod_q_q);
    shift_c = sum_c >>> SHIFT;
  end

  always_ff @(posedge clk) begin
    if (rst || !start) begin
      sample_o <= '0;
    end else if (shift_c > SAT_HI) begin
      sample_o <= SAT_HI[OUT_W-1:0];
    end else if (shift_c < SAT_LO) begin
      sample_o <= SAT_LO[OUT_W-1:0];
    end else begin
      sample_o <= shift_c[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/qam16_modulator.sv
module qam16_modulator
  import qam16_pkg::*;
#(
  parameter int LVL_W     = 16,
  parameter int AMP       = 2048,
  parameter int NCO_W     = 10,
  parameter int CAR_PAD   = 6,
  parameter int PHASE_W   = 12,
  parameter int PHASE_INC = 256,
  parameter int OUT_W     = 16,
  parameter int SHIFT     = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    bit_in,
  output logic [SYM_BITS-1:0]     sym_out,
  output logic signed [LVL_W-1:0] lvl_i,
  output logic signed [LVL_W-1:0] lvl_q,
  output logic signed [OUT_W-1:0] sample_out
);

  localparam int CAR_W = NCO_W + CAR_PAD;
  localparam int CNT_W = $clog2(SYM_BITS);

  logic                    sym_stb;
  logic [CNT_W-1:0]        bit_cnt;
  logic signed [CAR_W-1:0] car_cos;
  logic signed [CAR_W-1:0] car_sin;

  qam16_serial_split u_split (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .bit_in    (bit_in),
    .sym_o     (sym_out),
    .sym_stb_o (sym_stb),
    .bit_cnt_o (bit_cnt)
  );

  qam16_level_map #(
    .LVL_W (LVL_W),
    .AMP   (AMP)
  ) u_map (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .sym_stb (sym_stb),
    .sym_i   (sym_out),
    .lvl_i_o (lvl_i),
    .lvl_q_o (lvl_q)
  );

  qam16_nco #(
    .PHASE_W   (PHASE_W),
    .PHASE_INC (PHASE_INC),
    .NCO_W     (NCO_W),
    .CAR_PAD   (CAR_PAD)
  ) u_nco (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .cos_o (car_cos),
    .sin_o (car_sin)
  );

  qam16_mixer #(
    .LVL_W (LVL_W),
    .CAR_W (CAR_W),
    .OUT_W (OUT_W),
    .SHIFT (SHIFT)
  ) u_mix (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .lvl_i    (lvl_i),
    .lvl_q    (lvl_q),
    .car_cos  (car_cos),
    .car_sin  (car_sin),
    .sample_o (sample_out)
  );

endmodule

// File: rtl/qam16_modulator_chk.sv
module qam16_modulator_chk #(
  parameter int LVL_W   = 16,
  parameter int AMP     = 2048,
  parameter int NCO_W   = 10,
  parameter int CAR_PAD = 6,
  parameter int OUT_W   = 16
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            start,
  input logic [3:0]                      sym_out,
  input logic signed [LVL_W-1:0]         lvl_i,
  input logic signed [LVL_W-1:0]         lvl_q,
  input logic signed [OUT_W-1:0]         sample_out,
  input logic                            sym_stb,
  input logic [1:0]                      bit_cnt,
  input logic signed [NCO_W+CAR_PAD-1:0] car_cos,
  input logic signed [NCO_W+CAR_PAD-1:0] car_sin
);

  localparam int CAR_W  = NCO_W + CAR_PAD;
  localparam int PEAK   = (1 << (NCO_W - 1)) - 1;
  localparam int E_LO   = (PEAK * PEAK / 100) * 97;
  localparam int E_HI   = (PEAK * PEAK / 100) * 103;

  logic signed [NCO_W-1:0] cos_top;
  logic signed [NCO_W-1:0] sin_top;
  int energy;

  assign cos_top = car_cos[CAR_W-1 -: NCO_W];
  assign sin_top = car_sin[CAR_W-1 -: NCO_W];
  assign energy  = int'(cos_top) * int'(cos_top) + int'(sin_top) * int'(sin_top);

  // R1: a low start clears every output on the following cycle
  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    !start |=> (sym_out == '0 && lvl_i == '0 && lvl_q == '0 && sample_out == '0));

  // R2: the symbol only moves on the edge that takes the last bit of a group
  assert_sym_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (start && bit_cnt != 2'd3) |=> $stable(sym_out));

  // R3: levels are always one of the Gray-map values (or zero after clear)
  assert_level_legal_R3: assert property (@(posedge clk) disable iff (rst)
    (int'(lvl_i) inside {0, AMP, -AMP, 3*AMP, -3*AMP}) &&
    (int'(lvl_q) inside {0, AMP, -AMP, 3*AMP, -3*AMP}));

  // R4: no symbol strobe means the levels hold
  assert_level_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !sym_stb) |=> ($stable(lvl_i) && $stable(lvl_q)));

  // R5: a running oscillator keeps its carriers on the unit circle
  assert_carrier_energy_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> (energy >= E_LO && energy <= E_HI));

endmodule

bind qam16_modulator qam16_modulator_chk #(
  .LVL_W   (LVL_W),
  .AMP     (AMP),
  .NCO_W   (NCO_W),
  .CAR_PAD (CAR_PAD),
  .OUT_W   (OUT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .sym_out    (sym_out),
  .lvl_i      (lvl_i),
  .lvl_q      (lvl_q),
  .sample_out (sample_out),
  .sym_stb    (sym_stb),
  .bit_cnt    (bit_cnt),
  .car_cos    (car_cos),
  .car_sin    (car_sin)
);

// File: tb/qam16_modulator_test.sv
module qam16_modulator_test;

  localparam int AMP       = 2048;
  localparam int PHASE_W   = 12;
  localparam int PHASE_INC = 256;
  localparam int SHIFT     = 13;
  localparam int OUT_MAX   = 32767;
  localparam int OUT_MIN   = -32768;

  logic clk = 1'b0;
  logic rst;
  logic start;
  logic bit_in;
  logic [3:0]         sym_out;
  logic signed [15:0] lvl_i;
  logic signed [15:0] lvl_q;
  logic signed [15:0] sample_out;

  qam16_modulator uut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .bit_in     (bit_in),
    .sym_out    (sym_out),
    .lvl_i      (lvl_i),
    .lvl_q      (lvl_q),
    .sample_out (sample_out)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int weight(input logic [1:0] p);
    case (p)
      2'b00:   return -3;
      2'b01:   return -1;
      2'b11:   return 1;
      default: return 3;
    endcase
  endfunction

  function automatic int code_of(input int v);
    if (v == -3*AMP) return 0;
    if (v == -AMP)   return 1;
    if (v == AMP)    return 2;
    if (v == 3*AMP)  return 3;
    return -1;
  endfunction

  function automatic int tab(input int k);
    real r;
    r = 511.0 * $sin(2.0 * 3.14159265358979 * k / 16.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  function automatic int model_sample(input int li, input int lq, input int cc, input int ss);
    longint s;
    s = longint'(li) * cc * 64 + longint'(lq) * ss * 64;
    s = s >>> SHIFT;
    if (s > OUT_MAX) return OUT_MAX;
    if (s < OUT_MIN) return OUT_MIN;
    return int'(s);
  endfunction

  // Monitor / scoreboard
  int n = 0;
  logic [3:0] pend = '0;
  int e_li = 0, e_lq = 0;
  int h1_li = 0, h1_lq = 0, h1_c = 0, h1_s = 0;
  int h2_li = 0, h2_lq = 0, h2_c = 0, h2_s = 0;
  int sat_hi = 0, sat_lo = 0;
  logic [15:0] seen = '0;

  always @(negedge clk) begin
    if (rst || !start) begin
      n = 0;
      e_li = 0; e_lq = 0;
      h1_li = 0; h1_lq = 0; h1_c = 0; h1_s = 0;
      h2_li = 0; h2_lq = 0; h2_c = 0; h2_s = 0;
      chk(sym_out == 4'd0, "R1 sym_out cleared", sym_out, 0);
      chk(lvl_i == 0 && lvl_q == 0, "R1 levels cleared", lvl_i, 0);
      chk(sample_out == 0, "R1 sample cleared", sample_out, 0);
    end else begin
      int cc, ss, idx, es, ci, cq;
      n++;
      if (n % 4 == 0) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 scoreboard empty", sym_out, -1);
        end else begin
          pend = exp_q.pop_front();
          chk(sym_out == pend, "R2 parallel symbol", sym_out, pend);
        end
      end
      if (n % 4 == 1 && n >= 5) begin
        e_li = weight(pend[3:2]) * AMP;
        e_lq = weight(pend[1:0]) * AMP;
        chk(int'(lvl_i) == e_li, "R3 I level map", lvl_i, e_li);
        chk(int'(lvl_q) == e_lq, "R3 Q level map", lvl_q, e_lq);
        ci = code_of(int'(lvl_i));
        cq = code_of(int'(lvl_q));
        if (ci >= 0 && cq >= 0) seen[ci*4 + cq] = 1'b1;
      end else begin
        chk(int'(lvl_i) == e_li, "R4 I level hold", lvl_i, e_li);
        chk(int'(lvl_q) == e_lq, "R4 Q level hold", lvl_q, e_lq);
      end
      idx = (((n - 1) * PHASE_INC) % (1 << PHASE_W)) >> (PHASE_W - 4);
      ss  = tab(idx);
      cc  = tab((idx + 4) % 16);
      es  = model_sample(h2_li, h2_lq, h2_c, h2_s);
      chk(int'(sample_out) == es, "R5/R6 modulated sample", sample_out, es);
      if (es == OUT_MAX) sat_hi++;
      if (es == OUT_MIN) sat_lo++;
      h2_li = h1_li; h2_lq = h1_lq; h2_c = h1_c; h2_s = h1_s;
      h1_li = e_li;  h1_lq = e_lq;  h1_c = cc;   h1_s = ss;
    end
  end

  // Driver
  task automatic send_sym(input logic [3:0] s);
    exp_q.push_back(s);
    for (int b = 3; b >= 0; b--) begin
      @(negedge clk);
      #1;
      start  = 1'b1;
      bit_in = s[b];
    end
  endtask

  task automatic idle(input int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      #1;
      start  = 1'b0;
      bit_in = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst    = 1'b1;
    start  = 1'b0;
    bit_in = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    rst = 1'b0;
    idle(2);

    // Every symbol code, in order
    for (int s = 0; s < 16; s++) send_sym(4'(s));
    // Same-sign corner symbols across all carrier phases (saturation)
    for (int k = 0; k < 4; k++) send_sym(4'b1010);
    for (int k = 0; k < 4; k++) send_sym(4'b0000);
    // Mixed patterns
    send_sym(4'b0110);
    send_sym(4'b1001);
    send_sym(4'b1111);
    send_sym(4'b0101);
    // Flush so the last symbols reach the output
    send_sym(4'b0011);
    send_sym(4'b1100);
    idle(4);

    // Restart: phase and bit count begin again from zero
    send_sym(4'b1000);
    send_sym(4'b0111);
    send_sym(4'b1110);
    send_sym(4'b0001);
    send_sym(4'b1011);
    send_sym(4'b0100);
    idle(4);

    chk($countones(seen) == 16, "R8 distinct level pairs", $countones(seen), 16);
    chk(sat_hi > 0, "R7 positive clamp reached", sat_hi, 1);
    chk(sat_lo > 0, "R7 negative clamp reached", sat_lo, 1);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule